// File: doc/BRIEF.md
# Shared Interrupt Line Controller

This block collects a parameterised set of external interrupt lines and turns them into six prioritised output pins plus a vector number. Each line is shaped by three per-line settings: a polarity bit, a trigger-mode bit (level or edge) and a dual-edge enable. Software can also force a line pending, or withdraw a latched request, through a single injection word. That word carries both the line number and a set-or-clear flag.

A per-line enable mask gates the pending lines. Software changes the mask only through separate set and clear write addresses, and reads it back at a read-only address. Each enabled pending line is steered to one output pin by its own map word. The lowest-numbered active pin is reported as a vector equal to the pin index plus one. All registers sit on a simple synchronous bus: word address, write enable, write data and registered read data.

Register word addresses are: 0 polarity, 1 trigger mode, 2 dual-edge, 3 injection (write only), 4 mask set (write only), 5 mask clear (write only), 6 mask view (read only), 7 pending view (read only), and 8+i the map word of line i.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, polarity, trigger, dual-edge, mask and all map words read 0. With all inputs low, every line therefore reads pending (active-low, level), and no pin or vector is active.
- R2: In level mode (trigger bit 0), a line is pending while its input, after a two-flop synchroniser, equals its polarity bit: 1 means high is active, 0 means low is active.
- R3: In edge mode (trigger bit 1, dual bit 0), a rising input edge latches pending when polarity is 1, and a falling edge latches it when polarity is 0. The latch stays set after the input returns.
- R4: In edge mode with the dual bit 1, both rising and falling edges latch pending. The dual bit has no effect on a level-mode line.
- R5: Writing the injection word with bit 31 set makes the line numbered in bits 7:0 pending. With bit 31 clear, the write removes that line's latched pending. A line number of NUM_LINES or above is ignored. A level-mode line whose input is active stays pending after a clear.
- R6: A write to the mask-set address enables each line whose data bit is 1. A write to the mask-clear address disables each line whose data bit is 1. Zero bits leave the mask unchanged, and the mask reads back at address 6.
- R7: Address 7 reads the pending state of all lines: latched requests OR active level-mode inputs.
- R8: Map word bit 31 routes the line, and bits 5:0 pick the pin. A pin is the OR of all lines that are pending, enabled and routed to it. A pin number of NUM_PINS or above routes nowhere. The map word reads back only bit 31 and bits 5:0.
- R9: The vector output equals the lowest-numbered active pin plus one, and the valid flag is low when no pin is active.
- R10: Read data appears one clock after the address. Writes to the read-only view addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | External interrupt lines (asynchronous) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pin_out | output | NUM_PINS | Routed interrupt pins |
| vec_out | output | VW | Vector number of lowest active pin (pin+1) |
| vec_valid | output | 1 | High when any pin is active |

## Verification
The bench aims at the polarity inversion in edge mode. A design with it swapped would latch on the wrong transition and miss the intended one. It also tests that dual-edge is ignored on level lines and that out-of-range injection numbers are dropped; a design that wrapped the line number would corrupt a low-numbered line. Further targets are mask writes whose zero bits must leave lines untouched, map words naming a pin that does not exist, and the vector priority across several active pins, where a highest-first design would report the wrong number. Random phases mix input changes, injections, mask updates and remaps against a bench model of latched and level pending state.

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int NUM_PINS  = 6,
  parameter int AW        = 8,
  localparam int VW       = $clog2(NUM_PINS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [VW-1:0]        vec_out,
  output logic                 vec_valid
);
  localparam int N = NUM_LINES;
  localparam int MAP_BASE = 8;

  logic [N-1:0] pol_q, trig_q, dual_q, mask_q, latch_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] map_en_q;
  logic [5:0]   map_pin_q [N];
  logic [N-1:0] rise, fall, edge_hit, inj_vec, inj_set, inj_clr, pend, active;
  logic         inj_hit;
  logic [31:0]  rd_mux;

  wire wr_pol  = reg_we && reg_addr == AW'(0);
  wire wr_trig = reg_we && reg_addr == AW'(1);
  wire wr_dual = reg_we && reg_addr == AW'(2);
  wire wr_inj  = reg_we && reg_addr == AW'(3);
  wire wr_mset = reg_we && reg_addr == AW'(4);
  wire wr_mclr = reg_we && reg_addr == AW'(5);

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = trig_q & ((dual_q & (rise | fall)) |
                              (~dual_q & ((pol_q & rise) | (~pol_q & fall))));

  assign inj_hit = wr_inj && (int'(reg_wdata[7:0]) < N);
  assign inj_vec = N'(1) << reg_wdata[7:0];
  assign inj_set = (inj_hit && reg_wdata[31])  ? inj_vec : '0;
  assign inj_clr = (inj_hit && !reg_wdata[31]) ? inj_vec : '0;

  assign pend   = latch_q | (~trig_q & ~(sync2_q ^ pol_q));
  assign active = pend & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
      pol_q <= '0; trig_q <= '0; dual_q <= '0;
      mask_q <= '0; latch_q <= '0; map_en_q <= '0;
      for (int i = 0; i < N; i++) map_pin_q[i] <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr_pol)  pol_q  <= reg_wdata[N-1:0];
      if (wr_trig) trig_q <= reg_wdata[N-1:0];
      if (wr_dual) dual_q <= reg_wdata[N-1:0];
      if (wr_mset) mask_q <= mask_q | reg_wdata[N-1:0];
      if (wr_mclr) mask_q <= mask_q & ~reg_wdata[N-1:0];
      latch_q <= (latch_q & ~inj_clr) | inj_set | edge_hit;
      for (int i = 0; i < N; i++)
        if (reg_we && reg_addr == AW'(MAP_BASE + i)) begin
          map_en_q[i]  <= reg_wdata[31];
          map_pin_q[i] <= reg_wdata[5:0];
        end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      AW'(0): rd_mux = 32'(pol_q);
      AW'(1): rd_mux = 32'(trig_q);
      AW'(2): rd_mux = 32'(dual_q);
      AW'(6): rd_mux = 32'(mask_q);
      AW'(7): rd_mux = 32'(pend);
      default:
        for (int i = 0; i < N; i++)
          if (reg_addr == AW'(MAP_BASE + i))
            rd_mux = {map_en_q[i], 25'b0, map_pin_q[i]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_mux;

  always_comb begin
    pin_out = '0;
    for (int i = 0; i < N; i++)
      for (int p = 0; p < NUM_PINS; p++)
        if (active[i] && map_en_q[i] && map_pin_q[i] == 6'(p)) pin_out[p] = 1'b1;
  end

  always_comb begin
    vec_out = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--)
      if (pin_out[p]) vec_out = VW'(p + 1);
  end
  assign vec_valid = |pin_out;
endmodule

module irq_line_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int NUM_PINS  = 6,
  parameter int AW        = 8,
  localparam int VW       = $clog2(NUM_PINS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_PINS-1:0]  pin_out,
  input logic [VW-1:0]        vec_out,
  input logic                 vec_valid
);
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(4)) |=> ((mask_q & $past(reg_wdata[NUM_LINES-1:0])) == $past(reg_wdata[NUM_LINES-1:0]))); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(5)) |=> ((mask_q & $past(reg_wdata[NUM_LINES-1:0])) == '0)); // R6
  AST_INJ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(3) && reg_wdata[31] && int'(reg_wdata[7:0]) < NUM_LINES)
    |=> (((pend >> $past(reg_wdata[7:0])) & NUM_LINES'(1)) != '0)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (pin_out == '0)); // R8
  AST_VEC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (int'(vec_out) >= 1 && int'(vec_out) <= NUM_PINS &&
                   ((int'(pin_out) >> (int'(vec_out) - 1)) & 1) == 1 &&
                   (int'(pin_out) & ((1 << (int'(vec_out) - 1)) - 1)) == 0)); // R9
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (pin_out == '0)); // R9
endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS), .AW(AW)) u_chk (.*);

// File: tb/irq_line_ctrl_test.sv
`timescale 1ns/1ps
module irq_line_ctrl_test;
  logic        clk = 0, rst_n = 0, reg_we = 0;
  logic [31:0] irq_in = '0, reg_wdata = '0, reg_rdata;
  logic [7:0]  reg_addr = '0;
  logic [5:0]  pin_out;
  logic [2:0]  vec_out;
  logic        vec_valid;
  int n_chk = 0, n_err = 0;

  logic [31:0] m_pol = 0, m_trig = 0, m_dual = 0, m_mask = 0, m_latch = 0, m_in = 0;
  logic [31:0] m_en = 0;
  logic [5:0]  m_pin [32];

  irq_line_ctrl uut (.clk, .rst_n, .irq_in, .reg_we, .reg_addr, .reg_wdata,
                     .reg_rdata, .pin_out, .vec_out, .vec_valid);

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pend();
    return m_latch | (~m_trig & ~(m_in ^ m_pol));
  endfunction

  function automatic logic [5:0] exp_pins();
    logic [31:0] a = exp_pend() & m_mask;
    logic [5:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (a[i] && m_en[i] && m_pin[i] < 6) p[m_pin[i][2:0]] = 1'b1;
    return p;
  endfunction

  function automatic logic [3:0] exp_vec();
    logic [5:0] p = exp_pins();
    for (int k = 0; k < 6; k++) if (p[k]) return {1'b1, 3'(k + 1)};
    return 4'd0;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
    case (a)
      0: m_pol = d;
      1: m_trig = d;
      2: m_dual = d;
      3: if (d[7:0] < 32) begin
           if (d[31]) m_latch[d[4:0]] = 1'b1; else m_latch[d[4:0]] = 1'b0;
         end
      4: m_mask = m_mask | d;
      5: m_mask = m_mask & ~d;
      default: if (a >= 8 && a < 40) begin m_en[a-8] = d[31]; m_pin[a-8] = d[5:0]; end
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic drive(logic [31:0] v);
    logic [31:0] r = v & ~m_in, f = ~v & m_in;
    m_latch |= m_trig & ((m_dual & (r | f)) | (~m_dual & ((m_pol & r) | (~m_pol & f))));
    m_in = v;
    @(negedge clk); irq_in = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    logic [3:0] ev;
    rd(7, d); chk({req, " pending"}, d, exp_pend());
    rd(6, d); chk({req, " mask"}, d, m_mask);
    @(negedge clk);
    ev = exp_vec();
    chk({req, " pins"}, 32'(pin_out), 32'(exp_pins()));
    chk({req, " vector"}, {28'd0, vec_valid, vec_out}, 32'(ev));
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) m_pin[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(0, d); chk("R1 polarity", d, 0);
    rd(1, d); chk("R1 trigger", d, 0);
    rd(8, d); chk("R1 map", d, 0);
    check_all("R1");

    // R10 read-only view writes ignored
    wr(6, 32'hFFFF_FFFF); wr(7, 32'h0);
    m_mask = 0;
    check_all("R10");

    // R6 mask set/clear with zero bits untouched
    wr(4, 32'h0000_00FF); wr(5, 32'h0000_000A);
    check_all("R6");
    wr(4, 32'hFFFF_FFFF);

    // R8 routing, R9 priority
    wr(8 + 0, 32'h8000_0003); wr(8 + 1, 32'h8000_0001); wr(8 + 2, 32'h8000_0007);
    wr(8 + 3, 32'h0000_0000);
    rd(8 + 2, d); chk("R8 map readback", d, 32'h8000_0007);
    wr(8 + 4, 32'h7FFF_FFC2);
    rd(8 + 4, d); chk("R8 map readback bits", d, 32'h0000_0002);
    drive(32'hFFFF_FFF0);
    check_all("R8 R9 lines0-3 low active");

    // R2 level polarity
    wr(0, 32'h0000_0003);
    drive(32'h0000_0001);
    check_all("R2");

    // R3 edge single
    wr(0, 32'h0000_0001); wr(1, 32'h0000_0003); wr(2, 32'h0); wr(3, 32'h0); wr(3, 32'h1);
    drive(32'h0000_0002);
    check_all("R3 rise/fall");
    drive(32'h0000_0001);
    check_all("R3 latched hold");

    // R4 dual edge, and dual ignored on level line
    wr(3, 32'h0); wr(3, 32'h1); wr(2, 32'h0000_0005); wr(1, 32'h0000_0001);
    drive(32'h0000_0000);
    check_all("R4 dual falling");
    wr(3, 32'h0);
    drive(32'h0000_0001);
    check_all("R4 dual rising");
    drive(32'h0000_0005);
    check_all("R4 dual on level line");

    // R5 injection, out of range, level stays pending
    wr(3, 32'h8000_0005); wr(3, 32'h8000_0020); wr(3, 32'h0000_00FF);
    check_all("R5 inject");
    wr(3, 32'h0000_0002);
    check_all("R5 level clear");
    wr(3, 32'h0000_0005);
    check_all("R5 clear");

    // R7 random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(0, 5))
        0: drive($urandom);
        1: wr(3, {$urandom_range(0, 1) == 1, 23'd0, 8'($urandom_range(0, 40))});
        2: wr(4, $urandom);
        3: wr(5, $urandom);
        4: wr(8'(8 + $urandom_range(0, 31)), {$urandom_range(0, 1) == 1, 25'd0, 6'($urandom_range(0, 7))});
        default: wr(8'($urandom_range(0, 2)), $urandom);
      endcase
      check_all("R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule